// File: doc/BRIEF.md
# Binary Tree Row Route Configurator

This block works out how the switches of a binary routing tree must be set so that one leaf of the tree drives another leaf, using only the wires of that tree. The tree has `LEAVES` leaves and `LEAVES-1` switches. Switches are numbered in in-order traversal order, so each leaf owns the switch just before it. A switch at level L (level 1 sits directly above the leaves) that covers leaf block b has index `b*2^L + 2^(L-1) - 1`.

A request carries a source leaf and a destination leaf, and it arrives on a valid/ready handshake. While a route is being written, `req_ready` stays low, so a requester simply holds `req_valid` and its fields until they are taken. Once a request is accepted, every switch setting is derived combinationally from the latched pair in a single pass, and the logic depth grows with log2 of the leaf count. The settings then go out as configuration-memory writes over three cycles: first the switches on the source side, then those on the destination side, then the switch where the two paths meet. A one-cycle done pulse follows the writes. A request whose source equals its destination raises an error pulse instead and writes nothing.

Each switch field is 5 bits wide and is laid out as follows:
- bits [1:0] select the source of the upward output: 0 for none, 1 for the left child, 2 for the right child.
- bit 2 enables the downward output to the left child.
- bit 3 enables the downward output to the right child.
- bit 4 is the turn bit. When it is set, the enabled downward output takes its signal from the sibling child instead of from the parent.

Top module: `tree_route_cfg`

## Requirements
- R1: After reset, `req_ready` is 1, while `cfg_we`, `route_done` and `route_err` are all 0.
- R2: A request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is then low from the next cycle until the cycle after the done or error pulse.
- R3: In the first cycle after acceptance, the block writes every switch below the meeting point on the source leaf's path to the root. Each such field has bits[1:0] set to 1 when the source lies under the switch's left child and to 2 when it lies under the right child. All other bits of the field are 0.
- R4: In the second cycle, the block writes every switch below the meeting point on the destination leaf's path. Each such field has bit 2 set when the destination lies under the left child, bit 3 set when it lies under the right child, and all other bits 0.
- R5: In the third cycle, exactly one switch is written: the lowest switch common to both paths. Its field has bit 4 set, plus bit 2 or bit 3 toward the destination's side, and all other bits 0.
- R6: Switches that are not on the route are never written. This includes the common ancestors above the meeting switch. `cfg_data` is 0 for every switch whose write enable is low.
- R7: `route_done` pulses for exactly one cycle, in the cycle after the third write cycle.
- R8: A request with source equal to destination gives a one-cycle `route_err` pulse in the cycle after acceptance. It causes no write and no done pulse.
- R9: Switch j's enable is `cfg_we[j]` and its field is `cfg_data[5*j +: 5]`, where j follows the in-order numbering given above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A route request is present |
| req_ready | output | 1 | The block can take a request |
| req_src | input | IW | Source leaf index |
| req_dst | input | IW | Destination leaf index |
| cfg_we | output | LEAVES-1 | Per-switch configuration write enable |
| cfg_data | output | 5*(LEAVES-1) | Per-switch configuration fields |
| route_done | output | 1 | One-cycle pulse after the final write |
| route_err | output | 1 | One-cycle pulse for a rejected request |

## Verification
Two things can fall in the same cycle: a waiting request and the end of the previous route. The bench provokes this by holding `req_valid` high with the next pair of leaves while a route is still streaming out. It then checks that the new pair is not taken in the done cycle, that it is taken in the cycle right after, and that its writes never mix with the tail of the earlier route. An error request is also placed right behind a route and right before another, which shows that the error pulse and the done pulse never share a cycle.

// File: rtl/route_pkg.sv
package route_pkg;
  localparam int FW = 5;

  localparam logic [1:0] UP_NONE  = 2'd0;
  localparam logic [1:0] UP_LEFT  = 2'd1;
  localparam logic [1:0] UP_RIGHT = 2'd2;

  typedef struct packed {
    logic       turn;
    logic       dn_r;
    logic       dn_l;
    logic [1:0] up_sel;
  } sw_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WSRC, ST_WDST, ST_WMEET, ST_FIN, ST_ERR
  } wr_state_t;

  function automatic int sw_level(int j);
    int v;
    int l;
    v = j + 1;
    l = 1;
    while (v % 2 == 0) begin
      v = v / 2;
      l++;
    end
    return l;
  endfunction
endpackage

// File: rtl/route_path_logic.sv
module route_path_logic
  import route_pkg::*;
#(
  parameter int LEAVES = 8,
  localparam int IW  = $clog2(LEAVES),
  localparam int NSW = LEAVES - 1
) (
  input  logic [IW-1:0]     src,
  input  logic [IW-1:0]     dst,
  output logic [NSW-1:0]    src_mask,
  output logic [NSW-1:0]    dst_mask,
  output logic [NSW-1:0]    meet_mask,
  output logic [NSW*FW-1:0] fields
);
  for (genvar j = 0; j < NSW; j++) begin : g_sw
    localparam int LV  = sw_level(j);
    localparam int BLK = (j + 1) >> LV;
    logic    on_s, on_d, s_side, d_side;
    sw_cfg_t f;

    assign on_s   = (src >> LV) == IW'(BLK);
    assign on_d   = (dst >> LV) == IW'(BLK);
    assign s_side = src[LV-1];
    assign d_side = dst[LV-1];

    assign src_mask[j]  = on_s & ~on_d;
    assign dst_mask[j]  = on_d & ~on_s;
    assign meet_mask[j] = on_s & on_d & (s_side != d_side);

    always_comb begin
      f = '0;
      if (src_mask[j]) begin
        f.up_sel = s_side ? UP_RIGHT : UP_LEFT;
      end else if (dst_mask[j] || meet_mask[j]) begin
        f.dn_l = ~d_side;
        f.dn_r = d_side;
        f.turn = meet_mask[j];
      end
    end
    assign fields[j*FW +: FW] = f;
  end
endmodule

// File: rtl/route_write_seq.sv
module route_write_seq
  import route_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      bad,
  output wr_state_t state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else begin
      unique case (state)
        ST_IDLE:  if (start) state <= bad ? ST_ERR : ST_WSRC;
        ST_WSRC:  state <= ST_WDST;
        ST_WDST:  state <= ST_WMEET;
        ST_WMEET: state <= ST_FIN;
        ST_FIN:   state <= ST_IDLE;
        ST_ERR:   state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R7: after the done cycle the sequencer is back to idle
  a_r7_fin_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_FIN |=> state == ST_IDLE);
  // R8: an error cycle never leads into writes
  a_r8_err_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_ERR |=> state == ST_IDLE);
endmodule

// File: rtl/tree_route_cfg.sv
module tree_route_cfg
  import route_pkg::*;
#(
  parameter int LEAVES = 8,
  localparam int IW  = $clog2(LEAVES),
  localparam int NSW = LEAVES - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IW-1:0]     req_src,
  input  logic [IW-1:0]     req_dst,
  output logic [NSW-1:0]    cfg_we,
  output logic [NSW*FW-1:0] cfg_data,
  output logic              route_done,
  output logic              route_err
);
  wr_state_t          state;
  logic [IW-1:0]      src_q, dst_q;
  logic [NSW-1:0]     src_m, dst_m, meet_m;
  logic [NSW*FW-1:0]  fields;
  logic               accept;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid & req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
    end else if (accept) begin
      src_q <= req_src;
      dst_q <= req_dst;
    end
  end

  route_write_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept),
    .bad   (req_src == req_dst),
    .state (state)
  );

  route_path_logic #(.LEAVES(LEAVES)) u_path (
    .src       (src_q),
    .dst       (dst_q),
    .src_mask  (src_m),
    .dst_mask  (dst_m),
    .meet_mask (meet_m),
    .fields    (fields)
  );

  always_comb begin
    unique case (state)
      ST_WSRC:  cfg_we = src_m;
      ST_WDST:  cfg_we = dst_m;
      ST_WMEET: cfg_we = meet_m;
      default:  cfg_we = '0;
    endcase
  end

  for (genvar j = 0; j < NSW; j++) begin : g_gate
    assign cfg_data[j*FW +: FW] = fields[j*FW +: FW] & {FW{cfg_we[j]}};
  end

  assign route_done = (state == ST_FIN);
  assign route_err  = (state == ST_ERR);

  // R5: the meeting write touches exactly one switch
  a_r5_one_meet: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_WMEET |-> $countones(cfg_we) == 1);
  // R6: source and destination sides never share a switch
  a_r6_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    (src_m & dst_m) == '0 && (meet_m & (src_m | dst_m)) == '0);
  // R2: no request is taken while writes stream out
  a_r2_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (|cfg_we) |-> !req_ready);
  // R7: done follows a write cycle
  a_r7_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    route_done |-> $past(|cfg_we));
  // R8: error is quiet on the write port
  a_r8_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    route_err |-> (cfg_we == '0 && !route_done));
endmodule

// File: tb/sim_tree_route_cfg.sv
module sim_tree_route_cfg;
  localparam int LEAVES = 8;
  localparam int IW  = $clog2(LEAVES);
  localparam int NSW = LEAVES - 1;
  localparam int FW  = 5;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic req_ready;
  logic [IW-1:0] req_src = '0, req_dst = '0;
  logic [NSW-1:0] cfg_we;
  logic [NSW*FW-1:0] cfg_data;
  logic route_done, route_err;

  int errors = 0, checks = 0, cyc = 0;
  int m_state = 0, m_s = 0, m_d = 0;

  always #2 clk = ~clk;

  tree_route_cfg #(.LEAVES(LEAVES)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_src(req_src), .req_dst(req_dst), .cfg_we(cfg_we), .cfg_data(cfg_data),
    .route_done(route_done), .route_err(route_err)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Behavioural route: climb level by level until both leaves share a block.
  // R9: switch index at level L for block b is b*2^L + 2^(L-1) - 1.
  function automatic void exp_phase(int ph, int s, int d,
                                    output logic [NSW-1:0] we,
                                    output logic [NSW*FW-1:0] dat);
    we = '0;
    dat = '0;
    for (int lv = 1; lv <= IW; lv++) begin
      int a = s >> lv;
      int b = d >> lv;
      int ia = a * (1 << lv) + (1 << (lv - 1)) - 1;
      int ib = b * (1 << lv) + (1 << (lv - 1)) - 1;
      int sb = (s >> (lv - 1)) & 1;
      int db = (d >> (lv - 1)) & 1;
      if (a != b) begin
        if (ph == 1) begin we[ia] = 1; dat[ia*FW +: FW] = 5'(sb ? 2 : 1); end
        if (ph == 2) begin we[ib] = 1; dat[ib*FW +: FW] = 5'(db ? 8 : 4); end
      end else begin
        if (ph == 3) begin we[ia] = 1; dat[ia*FW +: FW] = 5'(16 + (db ? 8 : 4)); end
        break;
      end
    end
  endfunction

  // reference model, advanced on every clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_state <= 0;
    else begin
      cyc <= cyc + 1;
      case (m_state)
        0: if (req_valid) begin
             m_s <= int'(req_src);
             m_d <= int'(req_dst);
             m_state <= (req_src == req_dst) ? 5 : 1;
           end
        1: m_state <= 2;
        2: m_state <= 3;
        3: m_state <= 4;
        default: m_state <= 0;
      endcase
    end
  end

  // compared on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [NSW-1:0] ew;
      logic [NSW*FW-1:0] ed;
      string tg;
      exp_phase((m_state >= 1 && m_state <= 3) ? m_state : 0, m_s, m_d, ew, ed);
      tg = (m_state == 1) ? "R3" : (m_state == 2) ? "R4" : (m_state == 3) ? "R5" : "R6";
      check({"R2 ready"}, 64'(req_ready), 64'(m_state == 0));
      check({tg, " we"}, 64'(cfg_we), 64'(ew));
      check({tg, " R9 data"}, 64'(cfg_data), 64'(ed));
      check("R7 done", 64'(route_done), 64'(m_state == 4));
      check("R8 err", 64'(route_err), 64'(m_state == 5));
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=%0d exp<20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // call at a falling edge; returns at the falling edge after acceptance
  task automatic send(int s, int d);
    req_valid = 1;
    req_src = IW'(s);
    req_dst = IW'(d);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle(int n);
    req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1;
    // R1: reset state at the ports
    check("R1 ready", 64'(req_ready), 64'd1);
    check("R1 we", 64'(cfg_we), 64'd0);
    check("R1 done", 64'(route_done), 64'd0);
    check("R1 err", 64'(route_err), 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    send(0, 7);  idle(6);            // R3 R4 R5: full-height route
    send(7, 0);                      // back-to-back: held while busy (R2)
    send(3, 4);
    send(2, 3);                      // adjacent leaves: meeting only
    send(5, 5);                      // R8: rejected
    send(6, 1);
    idle(6);
    send(1, 0);  idle(1);
    send(4, 6);  send(4, 4);  send(2, 0);
    for (int s = 0; s < LEAVES; s++) send(s, (s * 3 + 1) % LEAVES);
    idle(8);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule